// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Decimal Adjust

This block is the arithmetic part of an 8-bit accumulator datapath. It takes the current accumulator, a second operand, the incoming carry, auxiliary-carry and overflow flags, and a 3-bit operation code. It returns the new accumulator value and the new flags. It supports add, add with carry, subtract with borrow, increment, decrement and a decimal-adjust step. The decimal adjust turns the binary sum of two packed-BCD bytes into a valid packed-BCD result, using the carry and auxiliary carry that the preceding add produced.

The arithmetic core is combinational. The parameter `REG_ACC` chooses how the outputs are driven. When it is 1 (the default), the result and the flags are captured in registers on a clock edge where `op_valid` is high, and they hold their values on every other edge. When it is 0, the outputs follow the core directly. Wider operations are built from byte steps: an add of the low bytes, then an add with carry of the high bytes.

Top module: `acc_alu`

## Requirements
- R1: With `REG_ACC`=1, reset clears `res_out`, `cy_out`, `ac_out` and `ov_out` to 0.
- R2: Code 0 (add) gives `res_out` = (acc_in + opnd_in) mod 256 and `cy_out` = the carry out of bit 7; `cy_in` is not used (44h+CAh gives 0Eh with carry 1).
- R3: Code 1 (add with carry) also adds `cy_in`, so the high byte of a 16-bit sum follows the low byte (1Eh+56h+1 gives 75h with carry 0).
- R4: For codes 0, 1 and 2, `ac_out` is the carry (or borrow) out of bit 3, and `ov_out` is the signed two's-complement overflow of the 8-bit result.
- R5: Code 2 (subtract with borrow) gives `res_out` = (acc_in - opnd_in - cy_in) mod 256, and `cy_out` is 1 exactly when a borrow occurs.
- R6: Code 3 (increment) and code 4 (decrement) wrap modulo 256 and pass `cy_in`, `ac_in` and `ov_in` through unchanged.
- R7: Code 5 (decimal adjust) adds 6 to the accumulator when its low nibble is above 9 or `ac_in` is 1 (6Ch gives 72h, 7Dh gives 83h).
- R8: In code 5, 60h is then added when the high nibble of that intermediate value is above 9, when `cy_in` is 1, or when the first step carried. `cy_out` is `cy_in` OR any carry out of bit 7, so it is never cleared. `ac_out` and `ov_out` pass through.
- R9: Codes 6 and 7 are reserved: `res_out` equals `acc_in`, and all flags pass through.
- R10: With `REG_ACC`=1, a clock edge with `op_valid` low leaves all four outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe; the registered outputs update only when it is high |
| op_sel | input | 3 | Operation code (0 add, 1 add with carry, 2 subtract with borrow, 3 increment, 4 decrement, 5 decimal adjust) |
| acc_in | input | 8 | Accumulator operand |
| opnd_in | input | 8 | Second operand |
| cy_in | input | 1 | Incoming carry/borrow flag |
| ac_in | input | 1 | Incoming auxiliary-carry flag |
| ov_in | input | 1 | Incoming overflow flag |
| res_out | output | 8 | Result (new accumulator) |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary-carry flag |
| ov_out | output | 1 | New overflow flag |

## Verification
The assertions check on every cycle that the outputs hold while the strobe is low, that add produces the 9-bit sum, that increment, decrement and the reserved codes pass the flags through, and that decimal adjust never clears a set carry. Only the bench's scenarios can show the specific nibble corrections of decimal adjust (low-nibble fix driven by the auxiliary carry, high-nibble fix driven by the carry), the exact auxiliary-carry and overflow values of add and subtract, and the two-step 16-bit add. The bench runs these chained sequences and a long random stream against its own behavioural model.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter bit REG_ACC = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [2:0] op_sel,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  input  logic       cy_in,
  input  logic       ac_in,
  input  logic       ov_in,
  output logic [7:0] res_out,
  output logic       cy_out,
  output logic       ac_out,
  output logic       ov_out
);
  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_ADDC = 3'd1;
  localparam logic [2:0] OP_SUBB = 3'd2;
  localparam logic [2:0] OP_INC  = 3'd3;
  localparam logic [2:0] OP_DEC  = 3'd4;
  localparam logic [2:0] OP_DA   = 3'd5;

  logic       c_use;
  logic [8:0] sum9, dif9, lo9, hi9;
  logic [4:0] hsum, hdif;
  logic       fix_lo, fix_hi;
  logic [7:0] r_n;
  logic       cy_n, ac_n, ov_n;

  assign c_use = (op_sel == OP_ADD) ? 1'b0 : cy_in;
  assign sum9  = {1'b0, acc_in} + {1'b0, opnd_in} + {8'd0, c_use};
  assign hsum  = {1'b0, acc_in[3:0]} + {1'b0, opnd_in[3:0]} + {4'd0, c_use};
  assign dif9  = {1'b0, acc_in} - {1'b0, opnd_in} - {8'd0, cy_in};
  assign hdif  = {1'b0, acc_in[3:0]} - {1'b0, opnd_in[3:0]} - {4'd0, cy_in};

  assign fix_lo = (acc_in[3:0] > 4'd9) || ac_in;
  assign lo9    = {1'b0, acc_in} + (fix_lo ? 9'h006 : 9'h000);
  assign fix_hi = (lo9[7:4] > 4'd9) || cy_in || lo9[8];
  assign hi9    = {1'b0, lo9[7:0]} + (fix_hi ? 9'h060 : 9'h000);

  always_comb begin
    r_n  = acc_in;
    cy_n = cy_in;
    ac_n = ac_in;
    ov_n = ov_in;
    case (op_sel)
      OP_ADD, OP_ADDC: begin
        r_n  = sum9[7:0];
        cy_n = sum9[8];
        ac_n = hsum[4];
        ov_n = (acc_in[7] == opnd_in[7]) && (sum9[7] != acc_in[7]);
      end
      OP_SUBB: begin
        r_n  = dif9[7:0];
        cy_n = dif9[8];
        ac_n = hdif[4];
        ov_n = (acc_in[7] != opnd_in[7]) && (dif9[7] != acc_in[7]);
      end
      OP_INC: r_n = acc_in + 8'd1;
      OP_DEC: r_n = acc_in - 8'd1;
      OP_DA: begin
        r_n  = hi9[7:0];
        cy_n = cy_in | lo9[8] | hi9[8];
      end
      default: ;
    endcase
  end

  generate
    if (REG_ACC) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_out <= 8'd0;
          cy_out  <= 1'b0;
          ac_out  <= 1'b0;
          ov_out  <= 1'b0;
        end else if (op_valid) begin
          res_out <= r_n;
          cy_out  <= cy_n;
          ac_out  <= ac_n;
          ov_out  <= ov_n;
        end
      end
    end else begin : g_comb
      assign res_out = r_n;
      assign cy_out  = cy_n;
      assign ac_out  = ac_n;
      assign ov_out  = ov_n;
    end
  endgenerate
endmodule

// File: rtl/acc_alu_sva.sv
module acc_alu_sva #(
  parameter bit REG_ACC = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [2:0] op_sel,
  input logic [7:0] acc_in,
  input logic [7:0] opnd_in,
  input logic       cy_in,
  input logic       ac_in,
  input logic       ov_in,
  input logic [7:0] res_out,
  input logic       cy_out,
  input logic       ac_out,
  input logic       ov_out
);
  logic gate_off;
  assign gate_off = !rst_n || !REG_ACC;

  assert_hold_R10: assert property (@(posedge clk) disable iff (gate_off)
    !op_valid |=> $stable(res_out) && $stable(cy_out) && $stable(ac_out) && $stable(ov_out));

  assert_add_sum_R2: assert property (@(posedge clk) disable iff (gate_off)
    op_valid && op_sel == 3'd0 |=>
      {cy_out, res_out} == {1'b0, $past(acc_in)} + {1'b0, $past(opnd_in)});

  assert_incdec_flags_R6: assert property (@(posedge clk) disable iff (gate_off)
    op_valid && (op_sel == 3'd3 || op_sel == 3'd4) |=>
      cy_out == $past(cy_in) && ac_out == $past(ac_in) && ov_out == $past(ov_in));

  assert_inc_wrap_R6: assert property (@(posedge clk) disable iff (gate_off)
    op_valid && op_sel == 3'd3 |=> res_out == $past(acc_in) + 8'd1);

  assert_da_keeps_carry_R8: assert property (@(posedge clk) disable iff (gate_off)
    op_valid && op_sel == 3'd5 && cy_in |=> cy_out);

  assert_da_flags_R8: assert property (@(posedge clk) disable iff (gate_off)
    op_valid && op_sel == 3'd5 |=> ac_out == $past(ac_in) && ov_out == $past(ov_in));

  assert_reserved_R9: assert property (@(posedge clk) disable iff (gate_off)
    op_valid && op_sel[2:1] == 2'b11 |=>
      res_out == $past(acc_in) && cy_out == $past(cy_in) && ac_out == $past(ac_in) && ov_out == $past(ov_in));
endmodule

bind acc_alu acc_alu_sva #(.REG_ACC(REG_ACC)) u_sva (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
  .acc_in(acc_in), .opnd_in(opnd_in), .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
  .res_out(res_out), .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out)
);

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_sel = 3'd0;
  logic [7:0] acc_in = 8'd0, opnd_in = 8'd0;
  logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
  logic [7:0] res_out;
  logic       cy_out, ac_out, ov_out;

  int tests = 0;
  int fails = 0;
  int m_res = 0, m_cy = 0, m_ac = 0, m_ov = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .acc_in(acc_in), .opnd_in(opnd_in), .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
    .res_out(res_out), .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out)
  );

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  task automatic model(input int op, input int a, input int b, input int c, input int h, input int o);
    int v, cc, s;
    m_res = a; m_cy = c; m_ac = h; m_ov = o;
    case (op)
      0, 1: begin
        cc = (op == 1) ? c : 0;
        v = a + b + cc;
        m_res = v % 256; m_cy = (v > 255);
        m_ac = ((a % 16) + (b % 16) + cc) > 15;
        s = sgn(a) + sgn(b) + cc;
        m_ov = (s > 127) || (s < -128);
      end
      2: begin
        v = a - b - c;
        m_res = (v + 256) % 256; m_cy = (v < 0);
        m_ac = (a % 16) < ((b % 16) + c);
        s = sgn(a) - sgn(b) - c;
        m_ov = (s > 127) || (s < -128);
      end
      3: m_res = (a + 1) % 256;
      4: m_res = (a + 255) % 256;
      5: begin
        v = a; cc = c;
        if ((v % 16) > 9 || h) v = v + 6;
        if (v > 255) cc = 1;
        if (((v / 16) % 16) > 9 || cc) v = v + 'h60;
        if (v > 255) cc = 1;
        m_res = v % 256; m_cy = cc;
      end
      default: ;
    endcase
  endtask

  task automatic check(input string req);
    tests++;
    if (res_out !== 8'(m_res) || cy_out !== 1'(m_cy) || ac_out !== 1'(m_ac) || ov_out !== 1'(m_ov)) begin
      fails++;
      $display("FAIL %s: got res=%02h cy=%0b ac=%0b ov=%0b, expected res=%02h cy=%0d ac=%0d ov=%0d",
               req, res_out, cy_out, ac_out, ov_out, m_res, m_cy, m_ac, m_ov);
    end
  endtask

  task automatic step(input string req, input bit vld, input int op, input int a, input int b,
                      input int c, input int h, input int o);
    op_valid = vld; op_sel = 3'(op); acc_in = 8'(a); opnd_in = 8'(b);
    cy_in = 1'(c); ac_in = 1'(h); ov_in = 1'(o);
    @(posedge clk);
    if (vld) model(op, a, b, c, h, o);
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    step("R2 add low byte", 1, 0, 'h44, 'hCA, 1, 0, 0);
    step("R3 addc high byte", 1, 1, 'h1E, 'h56, m_cy, m_ac, m_ov);
    step("R7 add 47+25", 1, 0, 'h47, 'h25, 0, 0, 0);
    step("R7 adjust 6C", 1, 5, res_out, 0, cy_out, ac_out, ov_out);
    step("R7 add 34+49", 1, 0, 'h34, 'h49, 0, 0, 0);
    step("R7 adjust 7D", 1, 5, res_out, 0, cy_out, ac_out, ov_out);
    step("R4 add 38+39 aux", 1, 0, 'h38, 'h39, 0, 0, 0);
    step("R7 adjust via aux", 1, 5, res_out, 0, cy_out, ac_out, ov_out);
    step("R8 add 99+99", 1, 0, 'h99, 'h99, 0, 0, 0);
    step("R8 adjust via carry", 1, 5, res_out, 0, cy_out, ac_out, ov_out);
    step("R8 carry kept", 1, 5, 'h12, 0, 1, 1, 1);
    step("R8 high fix overflow", 1, 5, 'hA5, 0, 0, 0, 0);
    step("R4 signed overflow add", 1, 0, 'h7F, 'h01, 0, 0, 0);
    step("R2 carry in ignored", 1, 0, 'h10, 'h20, 1, 0, 0);
    step("R5 subb half borrow", 1, 2, 'h10, 'h01, 1, 0, 0);
    step("R5 subb wrap borrow", 1, 2, 'h00, 'h01, 0, 0, 0);
    step("R4 subb signed overflow", 1, 2, 'h80, 'h01, 0, 0, 0);
    step("R6 inc wrap", 1, 3, 'hFF, 'h55, 1, 0, 1);
    step("R6 dec wrap", 1, 4, 'h00, 'h55, 0, 1, 1);
    step("R9 reserved 6", 1, 6, 'h5A, 'hFF, 1, 1, 0);
    step("R9 reserved 7", 1, 7, 'hC3, 'h01, 0, 0, 1);
    step("R10 hold", 0, 0, 'hFF, 'hFF, 1, 1, 1);
    step("R10 hold again", 0, 2, 'h00, 'h77, 0, 1, 0);

    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(7);
      step($sformatf("R%0d random", (op == 0) ? 2 : (op == 1) ? 3 : (op == 2) ? 5 :
                     (op < 5) ? 6 : (op == 5) ? 8 : 9),
           ($urandom_range(3) != 0), op, $urandom_range(255), $urandom_range(255),
           $urandom_range(1), $urandom_range(1), $urandom_range(1));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule